// File: doc/BRIEF.md
# Pipelined Segmented Carry-Lookahead Adder

This block adds two 24-bit unsigned operands and a carry-in. It is built as six 4-bit carry-lookahead segments, each in its own pipeline stage. Within a segment, all internal carries come from generate and propagate terms in one two-level step. Between segments, the carry passes through a register. Keeping the lookahead to four bits per stage keeps the logic small and the stage depth short.

A new operand pair can enter on every clock. The operand bits of higher segments pass through delay registers so that they meet the registered carry from the segment below. The sum bits of lower segments are held back so that all 24 sum bits, the carry-out and the valid flag leave the block in the same cycle. The result appears six clocks after the operands.

The datapath never stalls. The valid flag travels through the pipeline next to the data and does not gate the arithmetic.

Top module: `seg_cla_adder`

## Requirements
- R1: When valid_i is high with operands a_i, b_i and carry_i sampled at clock edge N, sum_o equals (a_i + b_i + carry_i) mod 2^24 after clock edge N+5.
- R2: carry_o equals bit 24 of a_i + b_i + carry_i and appears in the same cycle as the matching sum_o.
- R3: valid_o equals the valid_i value sampled five edges earlier. It is low at all other times, including the first six edges after reset.
- R4: Operands applied on consecutive clocks give results on consecutive clocks, in order, with no gaps or stalls.
- R5: A carry that enters at bit 0 reaches carry_o through all six segments. For example, 0xFFFFFF + 0x000000 + 1 gives sum_o = 0x000000 and carry_o = 1.
- R6: While rst_ni is low, sum_o, carry_o and valid_o are all 0. Results that were in flight when reset was asserted do not come out afterwards.
- R7: A carry produced at the top bit of one 4-bit segment (bit positions 3, 7, 11, 15 and 19) is added into the segment above. For example, 0x00000F + 0x000001 gives 0x000010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair is valid |
| a_i | input | 24 | First operand |
| b_i | input | 24 | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| valid_o | output | 1 | Result is valid |
| sum_o | output | 24 | Sum, aligned to valid_o |
| carry_o | output | 1 | Carry out of bit 23, aligned to valid_o |

## Verification
An error in the inter-segment carry register, or in an operand or sum delay line, shows at the ports as a wrong sum or carry. It appears in only a 4-bit slice of sum_o, or only on carry_o, and only for operand pairs that produce or carry through that slice. The bench therefore uses operands that carry across each segment boundary and operands that ripple through all six segments. A misaligned delay stage puts a neighbouring operand's bits into a slice of the result. Back-to-back streams of different operands expose this at the first result, six clocks after issue. Errors in reset or valid alignment show as valid_o at the wrong edge, or as a stale result appearing after reset.

// File: rtl/seg_cla_pkg.sv
package seg_cla_pkg;
  localparam int unsigned SEG_W_DEF   = 4;
  localparam int unsigned NUM_SEG_DEF = 6;
endpackage

// File: rtl/cla_delay_line.sv
module cla_delay_line #(
  parameter int unsigned W = 1,
  parameter int unsigned D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (D == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] q_q [D];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(D); i++) q_q[i] <= '0;
      end else begin
        q_q[0] <= d_i;
        for (int i = 1; i < int'(D); i++) q_q[i] <= q_q[i-1];
      end
    end
    assign q_o = q_q[D-1];
  end
endmodule

// File: rtl/cla_segment.sv
module cla_segment #(
  parameter int unsigned W = 4
) (
  input  logic         c_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         c_o
);
  logic [W-1:0] gen, prp;
  logic [W:0]   cy;

  assign gen = a_i & b_i;
  assign prp = a_i ^ b_i;

  // flat lookahead: c[i+1] = OR_j (g[j] & p[j+1..i]) | (p[0..i] & cin)
  always_comb begin
    cy[0] = c_i;
    for (int i = 0; i < int'(W); i++) begin
      logic term;
      logic chain;
      term  = 1'b0;
      for (int j = 0; j <= i; j++) begin
        chain = gen[j];
        for (int k = j + 1; k <= i; k++) chain = chain & prp[k];
        term = term | chain;
      end
      chain = c_i;
      for (int k = 0; k <= i; k++) chain = chain & prp[k];
      cy[i+1] = term | chain;
    end
  end

  assign sum_o = prp ^ cy[W-1:0];
  assign c_o   = cy[W];

  // R1: lookahead result matches plain addition of the slice
  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      a_r1_seg_sum: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(c_i)))
        else $error("segment sum mismatch");
    end
  end
endmodule

// File: rtl/cla_stage.sv
module cla_stage #(
  parameter int unsigned W       = 4,
  parameter int unsigned IN_DLY  = 0,
  parameter int unsigned OUT_DLY = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         c_o
);
  logic [2*W-1:0] ab_d;
  logic [W-1:0]   a_d, b_d, sum_c, sum_q;
  logic           c_c, c_q;

  cla_delay_line #(.W(2*W), .D(IN_DLY)) i_in_dly (
    .clk_i, .rst_ni, .d_i({a_i, b_i}), .q_o(ab_d)
  );
  assign a_d = ab_d[2*W-1:W];
  assign b_d = ab_d[W-1:0];

  cla_segment #(.W(W)) i_seg (
    .c_i(c_i), .a_i(a_d), .b_i(b_d), .sum_o(sum_c), .c_o(c_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      c_q   <= 1'b0;
    end else begin
      sum_q <= sum_c;
      c_q   <= c_c;
    end
  end
  assign c_o = c_q;

  cla_delay_line #(.W(W), .D(OUT_DLY)) i_out_dly (
    .clk_i, .rst_ni, .d_i(sum_q), .q_o(sum_o)
  );

  // R5: a fully propagating slice forwards the incoming carry unchanged
  logic prop_all;
  assign prop_all = &(a_d ^ b_d);
  a_r5_carry_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prop_all |=> (c_q == $past(c_i)))
    else $error("carry not forwarded through propagating slice");
endmodule

// File: rtl/seg_cla_adder.sv
module seg_cla_adder
  import seg_cla_pkg::*;
#(
  parameter int unsigned SEG_W   = SEG_W_DEF,
  parameter int unsigned NUM_SEG = NUM_SEG_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [SEG_W*NUM_SEG-1:0] a_i,
  input  logic [SEG_W*NUM_SEG-1:0] b_i,
  input  logic                     carry_i,
  output logic                     valid_o,
  output logic [SEG_W*NUM_SEG-1:0] sum_o,
  output logic                     carry_o
);
  localparam int unsigned WIDTH   = SEG_W * NUM_SEG;
  localparam int unsigned LATENCY = NUM_SEG;
  localparam int unsigned FILL_W  = $clog2(LATENCY + 1);

  logic [NUM_SEG:0] cy;
  assign cy[0] = carry_i;

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_stage
    cla_stage #(
      .W      (SEG_W),
      .IN_DLY (k),
      .OUT_DLY(NUM_SEG - 1 - k)
    ) i_stage (
      .clk_i,
      .rst_ni,
      .a_i  (a_i[k*SEG_W +: SEG_W]),
      .b_i  (b_i[k*SEG_W +: SEG_W]),
      .c_i  (cy[k]),
      .sum_o(sum_o[k*SEG_W +: SEG_W]),
      .c_o  (cy[k+1])
    );
  end

  assign carry_o = cy[NUM_SEG];

  cla_delay_line #(.W(1), .D(LATENCY)) i_vld_dly (
    .clk_i, .rst_ni, .d_i(valid_i), .q_o(valid_o)
  );

  // edges since reset, saturating; used only by the checks below
  logic [FILL_W-1:0] fill_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          fill_q <= '0;
    else if (fill_q != FILL_W'(LATENCY))  fill_q <= fill_q + 1'b1;
  end

  // R3: no valid result before the pipeline has filled
  a_r3_valid_after_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (fill_q == FILL_W'(LATENCY)))
    else $error("valid_o before pipeline filled");

  // R6: outputs cleared while reset is held
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r6_reset_clear: assert (!valid_o && !carry_o && sum_o == '0)
        else $error("outputs not cleared in reset");
    end
  end

  // R2: carry_o can only be set if the top operands were able to produce or pass a carry
  a_r2_carry_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cy[NUM_SEG-1]) == 1'b0 && fill_q == FILL_W'(LATENCY) && carry_o) |->
      (sum_o[WIDTH-1:WIDTH-SEG_W] != {SEG_W{1'b1}}))
    else $error("carry_o without a carry source");
endmodule

// File: tb/test_seg_cla_adder.sv
module test_seg_cla_adder;
  localparam int W   = 24;
  localparam int LAT = 6;
  localparam int NV  = 10;
  localparam int MAXN = 40;

  // {a, b, cin, expected {carry, sum}}
  localparam logic [73:0] VECS [NV] = '{
    {24'h000000, 24'h000000, 1'b0, 25'h0000000},  // reset-like zero
    {24'hFFFFFF, 24'h000000, 1'b1, 25'h1000000},  // R5 full ripple
    {24'hFFFFFF, 24'hFFFFFF, 1'b1, 25'h1FFFFFF},  // R2 all ones
    {24'h00000F, 24'h000001, 1'b0, 25'h0000010},  // R7 boundary 3->4
    {24'h0000FF, 24'h000001, 1'b0, 25'h0000100},  // R7 two boundaries
    {24'h123456, 24'h654321, 1'b0, 25'h0777777},
    {24'h800000, 24'h800000, 1'b0, 25'h1000000},  // R2 top-bit carry
    {24'h0F0F0F, 24'hF0F0F0, 1'b1, 25'h1000000},  // R5 propagate chain
    {24'hABCDEF, 24'h111111, 1'b0, 25'h0BCDF00},
    {24'h7FFFFF, 24'h000001, 1'b0, 25'h0800000}   // R7 boundary 19->20
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [W-1:0]  a = '0, b = '0;
  logic          cin = 1'b0;
  logic          valid_o, carry_o;
  logic [W-1:0]  sum_o;

  int errors = 0;
  int checks = 0;

  logic [W-1:0] sa [MAXN];
  logic [W-1:0] sb [MAXN];
  logic         sc [MAXN];
  logic [W:0]   se [MAXN];

  always #2.5ns clk = ~clk;

  seg_cla_adder i_seg_cla_adder (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .a_i(a), .b_i(b), .carry_i(cin),
    .valid_o(valid_o), .sum_o(sum_o), .carry_o(carry_o)
  );

  task automatic check(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive n vectors back to back; result of vector i is sampled LAT negedges later
  task automatic run_stream(input int n, input string req);
    for (int c = 0; c < n + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        check(valid_o == 1'b1, "R4 valid", {24'h0, valid_o}, 25'h1);
        check({carry_o, sum_o} == se[c-LAT], req, {carry_o, sum_o}, se[c-LAT]);
      end
      if (c < n) begin
        valid_i = 1'b1; a = sa[c]; b = sb[c]; cin = sc[c];
      end else begin
        valid_i = 1'b0; a = '0; b = '0; cin = 1'b0;
      end
    end
    @(negedge clk);
    check(valid_o == 1'b0, "R3 idle", {24'h0, valid_o}, 25'h0);
  endtask

  initial begin
    #(200000 * 5ns);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check({valid_o, carry_o, sum_o} == '0, "R6 reset", {carry_o, sum_o}, '0);
    rst_n = 1'b1;

    // R3: a single valid pulse appears exactly LAT negedges later
    @(negedge clk);
    valid_i = 1'b1; a = 24'h000001; b = 24'h000002;
    @(negedge clk);
    valid_i = 1'b0; a = '0; b = '0;
    for (int c = 1; c <= LAT + 1; c++) begin
      check(valid_o == (c == LAT), "R3 latency", {24'h0, valid_o}, {24'h0, c == LAT});
      if (c == LAT) check(sum_o == 24'h000003, "R1 single", {carry_o, sum_o}, 25'h3);
      @(negedge clk);
    end

    // table pass: R1 R2 R5 R7
    for (int i = 0; i < NV; i++) begin
      sa[i] = VECS[i][73:50]; sb[i] = VECS[i][49:26];
      sc[i] = VECS[i][25];    se[i] = VECS[i][24:0];
      check(se[i] == {1'b0, sa[i]} + {1'b0, sb[i]} + 25'(sc[i]), "R1 table", se[i],
            {1'b0, sa[i]} + {1'b0, sb[i]} + 25'(sc[i]));
    end
    run_stream(NV, "R1 R2 R5 R7 table");

    // random stream: R1 R2 R4
    for (int i = 0; i < MAXN; i++) begin
      sa[i] = W'($urandom); sb[i] = W'($urandom); sc[i] = 1'($urandom);
      se[i] = {1'b0, sa[i]} + {1'b0, sb[i]} + 25'(sc[i]);
    end
    run_stream(MAXN, "R1 R2 random");

    // R6: reset mid-stream drops in-flight results
    valid_i = 1'b1; a = 24'hFFFFFF; b = 24'hFFFFFF; cin = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    valid_i = 1'b0; a = '0; b = '0; cin = 1'b0;
    #1ns;
    check({valid_o, carry_o, sum_o} == '0, "R6 async clear", {carry_o, sum_o}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < LAT + 2; c++) begin
      @(negedge clk);
      check({valid_o, carry_o, sum_o} == '0, "R6 no stale result", {carry_o, sum_o}, '0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule